// File: doc/BRIEF.md
# Parallel Port Negotiation Edge Detector

This block watches two host control lines of a parallel peripheral port. It decides whether a change on them asks for mode negotiation or is an ordinary transfer strobe. Line A is active high, and its rising edge is the event of interest on that line. Line B is active low, and its falling edge is the event of interest on that line. Both lines are asynchronous. Each one passes through a two-flop synchronizer, and every decision uses the synchronized values.

The two lines move together only when the host wants to change modes. An A rise and a B fall that land within a programmable window of `win_len` clock samples raise a sticky negotiation flag, which tells the surrounding controller to drop its current mode. A lone B fall is a transfer strobe. If A is steady high, it is a nibble-read. If A is low, it is a compatibility-write. A transfer strobe is reported only after the window has closed without an A rise. The flag stays high until `flag_clr` or reset, and transfer pulses are suppressed while it is high.

Top module: `pp_nego_detect`

## Requirements
- R1: While `rst_n` is low and right after reset, `nego_flag`, `nibble_pulse` and `compat_pulse` are 0. The idle line levels are A = 0 and B = 1, so releasing reset on idle lines produces no event.
- R2: An A rise (0 to 1) and a B fall (1 to 0) in the same synchronized sample set `nego_flag`. The flag is visible after the third rising clock edge following the change of both raw lines, and no transfer pulse is produced.
- R3: With window W = `win_len` > 0, the flag is set and no transfer pulse is produced in either of these cases: a B fall detected 1 to W samples after an A rise, or an A rise detected 1 to W samples after a B fall. A separation of W+1 samples is not coincident, and the lone B fall is classified as a transfer strobe.
- R4: A B fall while A is low, with no A rise within the window, gives a one-cycle `compat_pulse`. The pulse is visible after the (3+W)-th rising edge following the raw B change.
- R5: A B fall while A is high and has not changed gives a one-cycle `nibble_pulse`, with the same timing as R4.
- R6: With `win_len` = 0, only a same-sample pair counts as coincident. A transfer pulse then appears after the third rising edge following the raw B change, and an A rise one sample later does not set the flag.
- R7: An A fall together with a B rise leaves the A/B parity unchanged, but it is the wrong direction. It neither sets the flag nor produces a pulse.
- R8: `nego_flag` stays high until `flag_clr` is high at a clock edge, and it is low after that edge. A new negotiation event in the same cycle wins over the clear.
- R9: While `nego_flag` is high, a transfer strobe whose window closes produces no pulse.
- R10: `nibble_pulse` and `compat_pulse` are each exactly one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_clr | input | 1 | One-cycle clear of the negotiation flag |
| line_a_raw | input | 1 | Asynchronous active-high host line A |
| line_b_raw | input | 1 | Asynchronous active-low host line B |
| win_len | input | WIN_W | Coincidence window in clock samples (0 = same sample only) |
| nego_flag | output | 1 | Sticky negotiation request flag |
| nibble_pulse | output | 1 | One-cycle nibble-read strobe |
| compat_pulse | output | 1 | One-cycle compatibility-write strobe |

## Verification
Counted from the cycle in which the bench changes a raw line, two synchronizer stages and the history register put the detected edge in the third cycle. The negotiation flag therefore shows three edges after the later of the two raw changes, and a transfer pulse shows 3+W edges after the raw B change. The driver pushes each expected transfer pulse into a scoreboard together with this computed due cycle. The monitor pops the item and compares both the kind and the cycle. A pulse that arrives early, late, of the wrong kind or unexpectedly counts as a failure, as does a due item that never appears. Flag checks sample exactly on the computed edge and, for the same-sample case, one edge earlier as well.

// File: rtl/pp_nego_pkg.sv
package pp_nego_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_AFTER_B = 2'd1,
    WIN_AFTER_A = 2'd2
  } win_state_e;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_NIBBLE = 2'd1,
    XFER_COMPAT = 2'd2
  } xfer_kind_e;

  // Both lines moved in one sample with the A^B parity kept, and in the
  // direction that asks for negotiation (A up, B down).
  function automatic logic pair_coincident(input logic a_now, input logic b_now,
                                           input logic a_prev, input logic b_prev);
    logic moved;
    logic parity_kept;
    moved       = (a_now ^ a_prev) | (b_now ^ b_prev);
    parity_kept = ((a_now ^ b_now) == (a_prev ^ b_prev));
    return moved && parity_kept && a_now && !b_now;
  endfunction

  // Kind of a B fall, judged by the level and history of A.
  function automatic xfer_kind_e classify_b_fall(input logic a_now, input logic a_prev);
    if (a_now && a_prev)
      return XFER_NIBBLE;
    else if (!a_now)
      return XFER_COMPAT;
    else
      return XFER_NONE;
  endfunction

endpackage

// File: rtl/pp_line_sync.sv
module pp_line_sync #(
  parameter int              LINES       = 2,
  parameter int              SYNC_STAGES = 2,
  parameter logic [LINES-1:0] IDLE_VAL   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_in,
  output logic [LINES-1:0] sync_out
);

  logic [LINES-1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= IDLE_VAL;
          else        stage_q[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= IDLE_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/pp_edge_track.sv
module pp_edge_track
  import pp_nego_pkg::*;
#(
  parameter logic A_IDLE = 1'b0,
  parameter logic B_IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_s,
  input  logic       b_s,
  output logic       a_rise,
  output logic       b_fall,
  output logic       pair_hit,
  output xfer_kind_e b_kind
);

  logic a_prev_q;
  logic b_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= A_IDLE;
      b_prev_q <= B_IDLE;
    end else begin
      a_prev_q <= a_s;
      b_prev_q <= b_s;
    end
  end

  assign a_rise   = a_s & ~a_prev_q;
  assign b_fall   = ~b_s & b_prev_q;
  assign pair_hit = pair_coincident(a_s, b_s, a_prev_q, b_prev_q);
  assign b_kind   = classify_b_fall(a_s, a_prev_q);

endmodule

// File: rtl/pp_window_classifier.sv
module pp_window_classifier
  import pp_nego_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_rise,
  input  logic             b_fall,
  input  logic             pair_hit,
  input  xfer_kind_e       b_kind,
  input  logic [WIN_W-1:0] win_len,
  output logic             nego_evt,
  output logic             xfer_emit,
  output xfer_kind_e       xfer_kind
);

  localparam logic [WIN_W-1:0] CNT_LAST = WIN_W'(1);

  win_state_e       state_q, state_d;
  logic [WIN_W-1:0] cnt_q, cnt_d;
  xfer_kind_e       kind_q, kind_d;
  logic             win_zero;

  assign win_zero = (win_len == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    kind_d    = kind_q;
    nego_evt  = 1'b0;
    xfer_emit = 1'b0;
    xfer_kind = kind_q;
    unique case (state_q)
      WIN_IDLE: begin
        if (pair_hit) begin
          nego_evt = 1'b1;
        end else if (b_fall) begin
          if (win_zero) begin
            xfer_emit = 1'b1;
            xfer_kind = b_kind;
          end else begin
            state_d = WIN_AFTER_B;
            cnt_d   = win_len;
            kind_d  = b_kind;
          end
        end else if (a_rise && !win_zero) begin
          state_d = WIN_AFTER_A;
          cnt_d   = win_len;
        end
      end
      WIN_AFTER_B: begin
        if (a_rise) begin
          nego_evt = 1'b1;
          state_d  = WIN_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          xfer_emit = 1'b1;
          state_d   = WIN_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_LAST;
        end
      end
      WIN_AFTER_A: begin
        if (b_fall) begin
          nego_evt = 1'b1;
          state_d  = WIN_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = WIN_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_LAST;
        end
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      kind_q  <= XFER_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

endmodule

// File: rtl/pp_nego_latch.sv
module pp_nego_latch
  import pp_nego_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nego_evt,
  input  logic       flag_clr,
  input  logic       xfer_emit,
  input  xfer_kind_e xfer_kind,
  output logic       nego_flag,
  output logic       nibble_pulse,
  output logic       compat_pulse
);

  logic flag_q;
  logic nib_q;
  logic cmp_q;
  logic pass_xfer;

  assign pass_xfer = xfer_emit & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      nib_q  <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      flag_q <= nego_evt | (flag_q & ~flag_clr);
      nib_q  <= pass_xfer && (xfer_kind == XFER_NIBBLE);
      cmp_q  <= pass_xfer && (xfer_kind == XFER_COMPAT);
    end
  end

  assign nego_flag    = flag_q;
  assign nibble_pulse = nib_q;
  assign compat_pulse = cmp_q;

endmodule

// File: rtl/pp_nego_detect.sv
module pp_nego_detect
  import pp_nego_pkg::*;
#(
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_clr,
  input  logic             line_a_raw,
  input  logic             line_b_raw,
  input  logic [WIN_W-1:0] win_len,
  output logic             nego_flag,
  output logic             nibble_pulse,
  output logic             compat_pulse
);

  localparam logic       A_IDLE   = 1'b0;
  localparam logic       B_IDLE   = 1'b1;
  localparam logic [1:0] IDLE_VEC = {B_IDLE, A_IDLE};

  logic [1:0] lines_s;
  logic       a_rise;
  logic       b_fall;
  logic       pair_hit;
  xfer_kind_e b_kind;
  logic       nego_evt;
  logic       xfer_emit;
  xfer_kind_e xfer_kind;

  pp_line_sync #(
    .LINES       (2),
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_VAL    (IDLE_VEC)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   ({line_b_raw, line_a_raw}),
    .sync_out (lines_s)
  );

  pp_edge_track #(
    .A_IDLE (A_IDLE),
    .B_IDLE (B_IDLE)
  ) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_s      (lines_s[0]),
    .b_s      (lines_s[1]),
    .a_rise   (a_rise),
    .b_fall   (b_fall),
    .pair_hit (pair_hit),
    .b_kind   (b_kind)
  );

  pp_window_classifier #(
    .WIN_W (WIN_W)
  ) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_rise    (a_rise),
    .b_fall    (b_fall),
    .pair_hit  (pair_hit),
    .b_kind    (b_kind),
    .win_len   (win_len),
    .nego_evt  (nego_evt),
    .xfer_emit (xfer_emit),
    .xfer_kind (xfer_kind)
  );

  pp_nego_latch i_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .nego_evt     (nego_evt),
    .flag_clr     (flag_clr),
    .xfer_emit    (xfer_emit),
    .xfer_kind    (xfer_kind),
    .nego_flag    (nego_flag),
    .nibble_pulse (nibble_pulse),
    .compat_pulse (compat_pulse)
  );

endmodule

// File: rtl/pp_nego_detect_chk.sv
module pp_nego_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_clr,
  input logic nego_evt,
  input logic nego_flag,
  input logic nibble_pulse,
  input logic compat_pulse
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!nego_flag && !nibble_pulse && !compat_pulse);
    end
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nego_evt |=> nego_flag);

  // R2
  nego_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nego_evt |=> !(nibble_pulse || compat_pulse));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nego_flag && !flag_clr) |=> nego_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !nego_evt) |=> !nego_flag);

  // R9
  xfer_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nego_flag |=> !(nibble_pulse || compat_pulse));

  // R10
  xfer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nibble_pulse, compat_pulse}));

  // R10
  nibble_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nibble_pulse |=> !nibble_pulse);

  // R10
  compat_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compat_pulse |=> !compat_pulse);

endmodule

bind pp_nego_detect pp_nego_detect_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flag_clr     (flag_clr),
  .nego_evt     (nego_evt),
  .nego_flag    (nego_flag),
  .nibble_pulse (nibble_pulse),
  .compat_pulse (compat_pulse)
);

// File: tb/test_pp_nego_detect.sv
module test_pp_nego_detect;

  localparam int WIN_W  = 4;
  localparam int K_NIB  = 1;
  localparam int K_CMP  = 2;

  typedef struct {
    int kind;
    int due;
    string req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_clr = 1'b0;
  logic line_a = 1'b0;
  logic line_b = 1'b1;
  logic [WIN_W-1:0] win_len = WIN_W'(2);
  logic nego_flag, nibble_pulse, compat_pulse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  pp_nego_detect #(.WIN_W(WIN_W)) i_pp_nego_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_clr     (flag_clr),
    .line_a_raw   (line_a),
    .line_b_raw   (line_b),
    .win_len      (win_len),
    .nego_flag    (nego_flag),
    .nibble_pulse (nibble_pulse),
    .compat_pulse (compat_pulse)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_xfer(input int kind, input int due, input string req);
    exp_item_t it;
    it.kind = kind;
    it.due  = due;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic check_flag(input logic exp, input string req);
    checks++;
    if (nego_flag !== exp) begin
      errors++;
      $display("FAIL %s: nego_flag at cycle %0d got %0b exp %0b", req, cyc, nego_flag, exp);
    end
  endtask

  // Monitor: compares transfer pulses against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: missing pulse kind got 0 exp %0d due cycle %0d", sb[0].req, sb[0].kind, sb[0].due);
        void'(sb.pop_front());
      end
      if (nibble_pulse || compat_pulse) begin
        int k;
        k = nibble_pulse ? K_NIB : K_CMP;
        checks++;
        if (sb.size() > 0 && sb[0].due == cyc && sb[0].kind == k) begin
          void'(sb.pop_front());
        end else begin
          errors++;
          $display("FAIL R10: unexpected pulse at cycle %0d got kind %0d exp %0d", cyc, k,
                   (sb.size() > 0 && sb[0].due == cyc) ? sb[0].kind : 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung got 1 exp 0");
      finish_run();
    end
  end

  initial begin
    int n;
    // R1 reset state
    step(4);
    checks++;
    if (nego_flag || nibble_pulse || compat_pulse) begin
      errors++;
      $display("FAIL R1: outputs in reset got %0b%0b%0b exp 000", nego_flag, nibble_pulse, compat_pulse);
    end
    rst_n = 1'b1;
    step(6);
    check_flag(1'b0, "R1");

    // R4 compatibility-write with A low
    n = cyc; line_b = 1'b0; expect_xfer(K_CMP, n + 5, "R4");
    step(10); check_flag(1'b0, "R4");
    line_b = 1'b1; step(6);

    // R5 nibble-read with A steady high
    line_a = 1'b1; step(10);
    n = cyc; line_b = 1'b0; expect_xfer(K_NIB, n + 5, "R5");
    step(10); line_b = 1'b1; line_a = 1'b0; step(8);

    // R2 same-sample pair
    n = cyc; line_a = 1'b1; line_b = 1'b0;
    step(2); check_flag(1'b0, "R2");
    step(1); check_flag(1'b1, "R2");
    step(5); check_flag(1'b1, "R8");

    // R9 suppression while flag high
    line_a = 1'b0; line_b = 1'b1; step(6);
    line_b = 1'b0; step(10);
    check_flag(1'b1, "R9");
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check_flag(1'b0, "R8");
    line_b = 1'b1; step(8);

    // R3 A then B, gap 2 (inside window)
    n = cyc; line_a = 1'b1; step(2); line_b = 1'b0;
    step(2); check_flag(1'b0, "R3");
    step(1); check_flag(1'b1, "R3");
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    line_a = 1'b0; line_b = 1'b1; step(8);

    // R3 B then A, gap 2 (inside window)
    n = cyc; line_b = 1'b0; step(2); line_a = 1'b1;
    step(3); check_flag(1'b1, "R3");
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    line_a = 1'b0; line_b = 1'b1; step(8);

    // R3 A then B, gap 3 (outside window -> nibble)
    n = cyc; line_a = 1'b1; step(3); line_b = 1'b0;
    expect_xfer(K_NIB, n + 8, "R3");
    step(8); check_flag(1'b0, "R3");
    line_a = 1'b0; line_b = 1'b1; step(8);

    // R3 B then A, gap 3 (outside window -> compat)
    n = cyc; line_b = 1'b0; expect_xfer(K_CMP, n + 5, "R3");
    step(3); line_a = 1'b1;
    step(8); check_flag(1'b0, "R3");
    line_b = 1'b1; step(8);

    // R7 A fall with B rise in one sample
    n = cyc; line_b = 1'b0; expect_xfer(K_NIB, n + 5, "R7");
    step(10);
    line_a = 1'b0; line_b = 1'b1;
    step(10); check_flag(1'b0, "R7");

    // R6 zero window
    win_len = '0; step(2);
    n = cyc; line_b = 1'b0; expect_xfer(K_CMP, n + 3, "R6");
    step(1); line_a = 1'b1;
    step(8); check_flag(1'b0, "R6");
    line_a = 1'b0; line_b = 1'b1; step(8);
    n = cyc; line_a = 1'b1; line_b = 1'b0;
    step(3); check_flag(1'b1, "R6");
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check_flag(1'b0, "R8");
    line_a = 1'b0; line_b = 1'b1; step(10);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: leftover expected pulses got %0d exp 0", sb.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule